// File: doc/BRIEF.md
# Gated Dual-Counter Snapshot Framer

This block measures two independent event streams over a fixed gate window. Each event input drives its own counter, and both counters advance only while the gate input is high. When the gate falls, both counts are frozen together into a single frame. The frame ends in a fixed trailer byte and is held for a downstream serial transmitter.

The gate and both event inputs are asynchronous. Each one passes through a multi-flop synchroniser into the single system clock before any logic looks at it, so nothing is ever clocked by the gate itself. When a gate period begins, the counters restart from zero. A ready/acknowledge pair hands the held frame to the consumer. An overrun flag reports a frame that was replaced before it was taken, and each counter has a sticky overflow flag that reports a wrap.

Top module: `gated_snapshot_framer`

## Requirements
- R1: While the synchronous active-high reset is applied, the held frame, ready, overrun and both overflow flags clear to zero, and they stay zero after reset until the first capture.
- R2: Each counter increments once for every rising edge of its own event input that is seen while the synchronised gate is high. The two channels count independently of each other.
- R3: Both counters clear on the clock cycle after the synchronised gate rises, so each frame holds only the events of its own gate period.
- R4: The frame is 72 bits wide. Channel A's count occupies bits 71:40, channel B's count occupies bits 39:8, and bits 7:0 hold the constant 0x0A.
- R5: On the clock cycle in which a falling gate is detected, both counts are captured into the frame together, and ready goes high.
- R6: The held frame does not change between captures, even while the counters advance during the next gate period.
- R7: A one-cycle acknowledge pulse with no capture in the same cycle clears ready and overrun.
- R8: If a capture occurs while ready is high and acknowledge is low, the frame is replaced by the new counts, ready stays high and overrun goes high.
- R9: If a capture and an acknowledge occur in the same cycle, the new frame is held, ready stays high and overrun is low.
- R10: A counter at its all-ones value that receives another event wraps to zero and sets its sticky overflow flag. The flag stays set until the next gate rise clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_in | input | 1 | Asynchronous measurement window; counting is enabled while it is high |
| evt_a_in | input | 1 | Asynchronous event input for channel A |
| evt_b_in | input | 1 | Asynchronous event input for channel B |
| ack_in | input | 1 | One-cycle pulse from the consumer; the held frame has been taken |
| frame_out | output | 72 | Held frame: channel A count, channel B count, trailer 0x0A |
| ready_out | output | 1 | A frame that has not been acknowledged is held |
| overrun_out | output | 1 | A frame that had not been acknowledged was replaced |
| ovf_a_out | output | 1 | Sticky wrap flag for channel A |
| ovf_b_out | output | 1 | Sticky wrap flag for channel B |

## Verification
The consumer's acknowledge and a new capture from the falling gate can land on the same clock edge. In that case the block must retire the old frame and hold the new one without reporting an overrun. To provoke this, the bench drops the gate and then counts off the synchroniser and edge-detector latency, so that the acknowledge pulse arrives exactly on the loading edge. It then checks that ready is high, overrun is low and the frame carries the new counts. The case where a capture arrives without any acknowledge is run separately, so the two outcomes can be told apart.

// File: rtl/snap_pkg.sv
package snap_pkg;

   localparam int unsigned DEF_CNT_W    = 32;
   localparam int unsigned DEF_TRAIL_W  = 8;
   localparam int unsigned DEF_SYNC     = 2;
   localparam int unsigned NUM_CH       = 2;

   // index of each asynchronous input inside the synchroniser bank
   localparam int unsigned IDX_GATE     = 0;
   localparam int unsigned IDX_CH0      = 1;

   function automatic int unsigned frame_width(int unsigned cnt_w, int unsigned trail_w);
      return NUM_CH * cnt_w + trail_w;
   endfunction

endpackage

// File: rtl/snap_sync.sv
// Multi-flop synchroniser with one extra history flop for edge detection.
module snap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic level,
   output logic prev
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];

endmodule

// File: rtl/snap_counter.sv
// Event counter with clear-priority, wrap at all-ones and sticky overflow.
module snap_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count,
   output logic         ovf
);

   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (inc) begin
         if (count == TOP) begin
            count <= '0;
            ovf   <= 1'b1;
         end else begin
            count <= count + 1'b1;
         end
      end
   end

endmodule

// File: rtl/snap_hold.sv
// Snapshot holding register with ready / acknowledge / overrun handling.
module snap_hold #(
   parameter int unsigned W = 72
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   input  logic         ack,
   output logic [W-1:0] q,
   output logic         ready,
   output logic         overrun
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q       <= '0;
         ready   <= 1'b0;
         overrun <= 1'b0;
      end else if (load) begin
         q       <= d;
         ready   <= 1'b1;
         overrun <= ready & ~ack;
      end else if (ack) begin
         ready   <= 1'b0;
         overrun <= 1'b0;
      end
   end

endmodule

// File: rtl/gated_snapshot_framer.sv
module gated_snapshot_framer #(
   parameter int unsigned CNT_W       = snap_pkg::DEF_CNT_W,
   parameter int unsigned TRAIL_W     = snap_pkg::DEF_TRAIL_W,
   parameter logic [TRAIL_W-1:0] TRAILER = 'h0A,
   parameter int unsigned SYNC_STAGES = snap_pkg::DEF_SYNC,
   localparam int unsigned FRAME_W    = snap_pkg::frame_width(CNT_W, TRAIL_W)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               gate_in,
   input  logic               evt_a_in,
   input  logic               evt_b_in,
   input  logic               ack_in,
   output logic [FRAME_W-1:0] frame_out,
   output logic               ready_out,
   output logic               overrun_out,
   output logic               ovf_a_out,
   output logic               ovf_b_out
);

   localparam int unsigned NUM_CH = snap_pkg::NUM_CH;
   localparam int unsigned NUM_IN = NUM_CH + 1;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (CNT_W >= 2)       else $error("CNT_W must be at least 2");
      assert (TRAIL_W >= 1)     else $error("TRAIL_W must be at least 1");
   end

   logic [NUM_IN-1:0] raw_in;
   logic [NUM_IN-1:0] lvl;
   logic [NUM_IN-1:0] prv;

   assign raw_in[snap_pkg::IDX_GATE]    = gate_in;
   assign raw_in[snap_pkg::IDX_CH0]     = evt_a_in;
   assign raw_in[snap_pkg::IDX_CH0 + 1] = evt_b_in;

   for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_sync
      snap_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst   (rst),
         .din   (raw_in[gi]),
         .level (lvl[gi]),
         .prev  (prv[gi])
      );
   end

   logic gate_lvl, gate_rise, gate_fall;
   assign gate_lvl  = lvl[snap_pkg::IDX_GATE];
   assign gate_rise =  gate_lvl & ~prv[snap_pkg::IDX_GATE];
   assign gate_fall = ~gate_lvl &  prv[snap_pkg::IDX_GATE];

   logic [CNT_W-1:0] cnt [NUM_CH];
   logic [NUM_CH-1:0] ovf;

   for (genvar ci = 0; ci < NUM_CH; ci++) begin : g_ch
      logic evt_rise;
      assign evt_rise = lvl[snap_pkg::IDX_CH0 + ci] & ~prv[snap_pkg::IDX_CH0 + ci];
      snap_counter #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst   (rst),
         .clr   (gate_rise),
         .inc   (gate_lvl & evt_rise),
         .count (cnt[ci]),
         .ovf   (ovf[ci])
      );
   end

   logic [FRAME_W-1:0] snap_d;
   always_comb begin
      snap_d = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         snap_d[FRAME_W-1-k*CNT_W -: CNT_W] = cnt[k];
      end
      snap_d[TRAIL_W-1:0] = TRAILER;
   end

   snap_hold #(.W(FRAME_W)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .load    (gate_fall),
      .d       (snap_d),
      .ack     (ack_in),
      .q       (frame_out),
      .ready   (ready_out),
      .overrun (overrun_out)
   );

   assign ovf_a_out = ovf[0];
   assign ovf_b_out = ovf[1];

endmodule

// File: rtl/snapshot_framer_checker.sv
module snapshot_framer_checker #(
   parameter int unsigned FRAME_W = 72,
   parameter int unsigned TRAIL_W = 8,
   parameter logic [TRAIL_W-1:0] TRAILER = 'h0A
) (
   input logic               clk,
   input logic               rst,
   input logic               gate_rise,
   input logic               gate_fall,
   input logic               ack_in,
   input logic [FRAME_W-1:0] frame_out,
   input logic               ready_out,
   input logic               overrun_out,
   input logic               ovf_a_out,
   input logic               ovf_b_out
);

   // R1: reset clears held state
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (frame_out == '0) && !ready_out && !overrun_out && !ovf_a_out && !ovf_b_out);

   // R4: a held frame always carries the trailer
   a_r4_trailer: assert property (@(posedge clk) disable iff (rst)
      ready_out |-> (frame_out[TRAIL_W-1:0] == TRAILER));

   // R5: detected falling gate raises ready
   a_r5_ready_after_fall: assert property (@(posedge clk) disable iff (rst)
      gate_fall |=> ready_out);

   // R6: frame only moves on a capture
   a_r6_frame_stable: assert property (@(posedge clk) disable iff (rst)
      !gate_fall |=> $stable(frame_out));

   // R7: acknowledge without capture drops ready and overrun
   a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
      (ack_in && !gate_fall) |=> (!ready_out && !overrun_out));

   // R8: capture over an unacknowledged frame flags overrun
   a_r8_overrun: assert property (@(posedge clk) disable iff (rst)
      (gate_fall && ready_out && !ack_in) |=> (ready_out && overrun_out));

   // R9: capture with simultaneous acknowledge is clean
   a_r9_same_cycle: assert property (@(posedge clk) disable iff (rst)
      (gate_fall && ack_in) |=> (ready_out && !overrun_out));

   // R10: gate rise clears sticky overflow
   a_r10_ovf_cleared: assert property (@(posedge clk) disable iff (rst)
      gate_rise |=> (!ovf_a_out && !ovf_b_out));

endmodule

bind gated_snapshot_framer snapshot_framer_checker #(
   .FRAME_W (FRAME_W),
   .TRAIL_W (TRAIL_W),
   .TRAILER (TRAILER)
) u_check (
   .clk         (clk),
   .rst         (rst),
   .gate_rise   (gate_rise),
   .gate_fall   (gate_fall),
   .ack_in      (ack_in),
   .frame_out   (frame_out),
   .ready_out   (ready_out),
   .overrun_out (overrun_out),
   .ovf_a_out   (ovf_a_out),
   .ovf_b_out   (ovf_b_out)
);

// File: tb/gated_snapshot_framer_bench.sv
module gated_snapshot_framer_bench;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic gate = 1'b0, evt_a = 1'b0, evt_b = 1'b0, ack = 1'b0;

   logic [71:0] frame;
   logic        ready, overrun, ovf_a, ovf_b;
   logic [15:0] s_frame;
   logic        s_ready, s_overrun, s_ovf_a, s_ovf_b;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gated_snapshot_framer u_gated_snapshot_framer (
      .clk(clk), .rst(rst), .gate_in(gate), .evt_a_in(evt_a), .evt_b_in(evt_b),
      .ack_in(ack), .frame_out(frame), .ready_out(ready), .overrun_out(overrun),
      .ovf_a_out(ovf_a), .ovf_b_out(ovf_b)
   );

   // narrow variant so that counter wrap is reachable
   gated_snapshot_framer #(.CNT_W(4)) u_gated_snapshot_framer_small (
      .clk(clk), .rst(rst), .gate_in(gate), .evt_a_in(evt_a), .evt_b_in(evt_b),
      .ack_in(ack), .frame_out(s_frame), .ready_out(s_ready), .overrun_out(s_overrun),
      .ovf_a_out(s_ovf_a), .ovf_b_out(s_ovf_b)
   );

   function automatic logic [71:0] mk(int a, int b);
      logic [31:0] av = a[31:0];
      logic [31:0] bv = b[31:0];
      return {av, bv, 8'h0A};
   endfunction

   function automatic logic [71:0] mk_small(int a, int b);
      logic [3:0] av = a[3:0];
      logic [3:0] bv = b[3:0];
      return {56'd0, av, bv, 8'h0A};
   endfunction

   task automatic chk(string req, string what, logic [71:0] act, logic [71:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic pulses(int na, int nb);
      int top = (na > nb) ? na : nb;
      for (int i = 0; i < top; i++) begin
         evt_a = (i < na);
         evt_b = (i < nb);
         repeat (2) @(negedge clk);
         evt_a = 1'b0;
         evt_b = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic run_period(int na, int nb);
      gate = 1'b1;
      repeat (4) @(negedge clk);
      pulses(na, nb);
      repeat (2) @(negedge clk);
      gate = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic do_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", "frame", frame, '0);
      chk("R1", "ready", {71'd0, ready}, 72'd0);
      chk("R1", "overrun", {71'd0, overrun}, 72'd0);
      chk("R1", "ovf", {70'd0, ovf_a, ovf_b}, 72'd0);
   endtask

   task automatic t_basic();
      run_period(5, 3);
      chk("R2", "frame counts 5/3", frame, mk(5, 3));
      chk("R4", "trailer", {64'd0, frame[7:0]}, 72'h0A);
      chk("R5", "ready", {71'd0, ready}, 72'd1);
      chk("R5", "overrun", {71'd0, overrun}, 72'd0);
   endtask

   task automatic t_ack_and_stable();
      do_ack();
      chk("R7", "ready after ack", {71'd0, ready}, 72'd0);
      gate = 1'b1;
      repeat (4) @(negedge clk);
      pulses(6, 2);
      chk("R6", "frame mid-period", frame, mk(5, 3));
      chk("R6", "ready mid-period", {71'd0, ready}, 72'd0);
      repeat (2) @(negedge clk);
      gate = 1'b0;
      repeat (5) @(negedge clk);
      chk("R3", "fresh counts 6/2", frame, mk(6, 2));
   endtask

   task automatic t_overrun();
      run_period(1, 4);
      chk("R8", "frame replaced", frame, mk(1, 4));
      chk("R8", "ready", {71'd0, ready}, 72'd1);
      chk("R8", "overrun", {71'd0, overrun}, 72'd1);
      do_ack();
      chk("R7", "ready cleared", {71'd0, ready}, 72'd0);
      chk("R7", "overrun cleared", {71'd0, overrun}, 72'd0);
   endtask

   task automatic t_same_cycle();
      run_period(2, 2);
      chk("R5", "ready before collision", {71'd0, ready}, 72'd1);
      gate = 1'b1;
      repeat (4) @(negedge clk);
      pulses(4, 0);
      repeat (2) @(negedge clk);
      gate = 1'b0;
      @(negedge clk);
      @(negedge clk);
      ack = 1'b1;          // lands on the capture edge
      @(negedge clk);
      ack = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9", "frame", frame, mk(4, 0));
      chk("R9", "ready", {71'd0, ready}, 72'd1);
      chk("R9", "overrun", {71'd0, overrun}, 72'd0);
      do_ack();
   endtask

   task automatic t_wrap();
      run_period(17, 18);
      chk("R10", "narrow frame wrapped", {56'd0, s_frame}, mk_small(17, 18));
      chk("R10", "narrow ovf", {70'd0, s_ovf_a, s_ovf_b}, 72'd3);
      chk("R10", "wide frame", frame, mk(17, 18));
      chk("R10", "wide ovf", {70'd0, ovf_a, ovf_b}, 72'd0);
      do_ack();
      chk("R10", "ovf sticky while gate low", {70'd0, s_ovf_a, s_ovf_b}, 72'd3);
      gate = 1'b1;
      repeat (4) @(negedge clk);
      chk("R10", "ovf cleared by gate rise", {70'd0, s_ovf_a, s_ovf_b}, 72'd0);
      repeat (2) @(negedge clk);
      gate = 1'b0;
      repeat (5) @(negedge clk);
      chk("R3", "empty period", {56'd0, s_frame}, mk_small(0, 0));
      do_ack();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_basic();
      t_ack_and_stable();
      t_overrun();
      t_same_cycle();
      t_wrap();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule